// File: doc/BRIEF.md
# Barrel Thread Scheduler with Suspension

This block picks, every cycle, which hardware thread of a multithreaded soft core may issue its next instruction. Threads are visited in rotating order. A thread can have at most one instruction in the pipeline at once. For this reason the core needs no forwarding, stall or hazard logic. Once a thread issues, it waits in the busy state until its instruction retires. It can instead be parked by a suspend request when the instruction has a long or unknown latency, such as a floating-point operation or an off-chip memory access.

A parked thread stays out of the rotation until the long-latency unit sends a resume carrying that thread's ID. The front end accepts the offered thread with a ready handshake. When no thread is eligible, the block offers nothing and the pipeline gets a bubble. The thread count is a parameter, intended for 16 or 32 threads per core.

Top module: `barrel_sched`

## Requirements
- R1: After reset every thread is ready and the search pointer is 0, so the first offer is thread 0 with issue_valid_o high.
- R2: The search for a ready thread begins at the thread after the one most recently issued and wraps modulo the thread count. With all threads ready and issue_ready_i held high, threads issue in the order 0, 1, 2, and so on.
- R3: Only ready threads are offered. An accepted offer (issue_valid_o and issue_ready_i both high) moves that thread to busy, and it is not offered again until it returns to ready.
- R4: When no thread is ready, issue_valid_o is low for that cycle.
- R5: A retire naming a busy thread returns it to ready on the next cycle.
- R6: A suspend and a retire naming the same busy thread in the same cycle park that thread: the suspend wins.
- R7: A parked thread is never offered until a resume names its ID.
- R8: A resume naming a thread that is not parked has no effect.
- R9: A resume for one thread and a retire for a different thread in the same cycle both take effect.
- R10: While issue_ready_i is low, no thread changes state through issue and the search pointer holds.
- R11: A retire or suspend naming a thread that is not busy has no effect.

Thread IDs on every port are plain binary thread numbers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_ready_i | input | 1 | Front end accepts the offered thread this cycle |
| retire_valid_i | input | 1 | An instruction retires |
| retire_tid_i | input | TID_W | Thread of the retiring instruction |
| suspend_valid_i | input | 1 | Park a thread for a long-latency operation |
| suspend_tid_i | input | TID_W | Thread to park |
| resume_valid_i | input | 1 | A long-latency result is back |
| resume_tid_i | input | TID_W | Thread whose result is back |
| issue_valid_o | output | 1 | A ready thread is offered |
| issue_tid_o | output | TID_W | Offered thread |

## Verification
The hardest cases to reach are cycles in which several thread events collide. One is a suspend and a retire naming the same busy thread. Another is a resume and a retire for different threads arriving together while the rotation is close to empty. Uniformly random IDs rarely hit these, so the random stimulus draws retire IDs mostly from threads the bench model knows are busy, and resume IDs mostly from parked threads. It also copies the retire ID into the suspend ID in a fixed share of cycles. Directed sequences first drain all threads to force bubbles, then build each collision on purpose.

// File: rtl/barrel_sched_pkg.sv
package barrel_sched_pkg;
  typedef enum logic [1:0] {
    THR_READY  = 2'd0,
    THR_BUSY   = 2'd1,
    THR_PARKED = 2'd2
  } thr_state_e;
endpackage

// File: rtl/tid_decoder.sv
module tid_decoder #(
  parameter int NUM_THREADS = 16,
  parameter int TID_W       = $clog2(NUM_THREADS)
) (
  input  logic                   valid_i,
  input  logic [TID_W-1:0]       tid_i,
  output logic [NUM_THREADS-1:0] hit_o
);
  for (genvar g = 0; g < NUM_THREADS; g++) begin : g_hit
    assign hit_o[g] = valid_i && (tid_i == TID_W'(g));
  end
endmodule

// File: rtl/thread_slot.sv
module thread_slot
  import barrel_sched_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       issue_i,
  input  logic       retire_i,
  input  logic       suspend_i,
  input  logic       resume_i,
  output thr_state_e state_o
);
  thr_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      THR_READY:  if (issue_i) state_d = THR_BUSY;
      THR_BUSY: begin
        // suspend beats retire for the same thread
        if (suspend_i)     state_d = THR_PARKED;
        else if (retire_i) state_d = THR_READY;
      end
      THR_PARKED: if (resume_i) state_d = THR_READY;
      default:    state_d = THR_READY;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= THR_READY;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/rr_picker.sv
module rr_picker #(
  parameter int NUM_THREADS = 16,
  parameter int TID_W       = $clog2(NUM_THREADS)
) (
  input  logic [NUM_THREADS-1:0] ready_i,
  input  logic [TID_W-1:0]       start_i,
  output logic                   found_o,
  output logic [TID_W-1:0]       sel_o
);
  always_comb begin
    found_o = 1'b0;
    sel_o   = '0;
    // scan backwards so the nearest ready thread from start_i wins
    for (int i = NUM_THREADS - 1; i >= 0; i--) begin
      int idx;
      idx = (int'(start_i) + i) % NUM_THREADS;
      if (ready_i[idx]) begin
        found_o = 1'b1;
        sel_o   = TID_W'(idx);
      end
    end
  end
endmodule

// File: rtl/barrel_sched.sv
module barrel_sched
  import barrel_sched_pkg::*;
#(
  parameter int NUM_THREADS = 16,
  localparam int TID_W      = $clog2(NUM_THREADS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             issue_ready_i,
  input  logic             retire_valid_i,
  input  logic [TID_W-1:0] retire_tid_i,
  input  logic             suspend_valid_i,
  input  logic [TID_W-1:0] suspend_tid_i,
  input  logic             resume_valid_i,
  input  logic [TID_W-1:0] resume_tid_i,
  output logic             issue_valid_o,
  output logic [TID_W-1:0] issue_tid_o
);
  thr_state_e             thr_st [NUM_THREADS];
  logic [NUM_THREADS-1:0] ready_vec;
  logic [NUM_THREADS-1:0] issue_hit, retire_hit, suspend_hit, resume_hit;
  logic [TID_W-1:0]       start_q;
  logic                   found;
  logic [TID_W-1:0]       sel;
  logic                   fire;

  rr_picker #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) i_picker (
    .ready_i (ready_vec),
    .start_i (start_q),
    .found_o (found),
    .sel_o   (sel)
  );

  assign fire = found && issue_ready_i;

  tid_decoder #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) i_dec_issue (
    .valid_i (fire), .tid_i (sel), .hit_o (issue_hit));
  tid_decoder #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) i_dec_retire (
    .valid_i (retire_valid_i), .tid_i (retire_tid_i), .hit_o (retire_hit));
  tid_decoder #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) i_dec_suspend (
    .valid_i (suspend_valid_i), .tid_i (suspend_tid_i), .hit_o (suspend_hit));
  tid_decoder #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) i_dec_resume (
    .valid_i (resume_valid_i), .tid_i (resume_tid_i), .hit_o (resume_hit));

  for (genvar g = 0; g < NUM_THREADS; g++) begin : g_slot
    thread_slot i_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .issue_i   (issue_hit[g]),
      .retire_i  (retire_hit[g]),
      .suspend_i (suspend_hit[g]),
      .resume_i  (resume_hit[g]),
      .state_o   (thr_st[g])
    );
    assign ready_vec[g] = (thr_st[g] == THR_READY);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   start_q <= '0;
    else if (fire) start_q <= TID_W'((int'(sel) + 1) % NUM_THREADS);
  end

  assign issue_valid_o = found;
  assign issue_tid_o   = sel;
endmodule

// File: rtl/barrel_sched_chk.sv
module barrel_sched_chk
  import barrel_sched_pkg::*;
#(
  parameter int NUM_THREADS = 16,
  parameter int TID_W       = $clog2(NUM_THREADS)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             issue_ready_i,
  input logic             retire_valid_i,
  input logic [TID_W-1:0] retire_tid_i,
  input logic             suspend_valid_i,
  input logic [TID_W-1:0] suspend_tid_i,
  input logic             resume_valid_i,
  input logic [TID_W-1:0] resume_tid_i,
  input logic             issue_valid_o,
  input logic [TID_W-1:0] issue_tid_o,
  input thr_state_e       st_i [NUM_THREADS]
);
  logic any_ready;
  always_comb begin
    any_ready = 1'b0;
    for (int i = 0; i < NUM_THREADS; i++)
      if (st_i[i] == THR_READY) any_ready = 1'b1;
  end

  p_offer_ready_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o |-> st_i[issue_tid_o] == THR_READY);

  p_accept_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o && issue_ready_i |=> st_i[$past(issue_tid_o)] == THR_BUSY);

  p_bubble_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_valid_o |-> !any_ready);

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_ready_i && !retire_valid_i && !suspend_valid_i && !resume_valid_i
    |=> $stable(issue_valid_o) && $stable(issue_tid_o));

  for (genvar g = 0; g < NUM_THREADS; g++) begin : g_thr
    logic ret_g, sus_g, res_g;
    assign ret_g = retire_valid_i  && retire_tid_i  == TID_W'(g);
    assign sus_g = suspend_valid_i && suspend_tid_i == TID_W'(g);
    assign res_g = resume_valid_i  && resume_tid_i  == TID_W'(g);

    p_retire_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      st_i[g] == THR_BUSY && ret_g && !sus_g |=> st_i[g] == THR_READY);

    p_suspend_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      st_i[g] == THR_BUSY && sus_g |=> st_i[g] == THR_PARKED);

    p_parked_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      st_i[g] == THR_PARKED && !res_g |=> st_i[g] == THR_PARKED);

    p_resume_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      st_i[g] == THR_BUSY && res_g && !ret_g && !sus_g |=> st_i[g] == THR_BUSY);

    p_resume_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      st_i[g] == THR_PARKED && res_g |=> st_i[g] == THR_READY);
  end
endmodule

bind barrel_sched barrel_sched_chk #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) i_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .issue_ready_i   (issue_ready_i),
  .retire_valid_i  (retire_valid_i),
  .retire_tid_i    (retire_tid_i),
  .suspend_valid_i (suspend_valid_i),
  .suspend_tid_i   (suspend_tid_i),
  .resume_valid_i  (resume_valid_i),
  .resume_tid_i    (resume_tid_i),
  .issue_valid_o   (issue_valid_o),
  .issue_tid_o     (issue_tid_o),
  .st_i            (thr_st)
);

// File: tb/test_barrel_sched.sv
`timescale 1ns/1ps
module test_barrel_sched;
  localparam int N     = 16;
  localparam int TID_W = $clog2(N);
  localparam int S_RDY = 0, S_BSY = 1, S_PRK = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic issue_ready_i = 1'b0;
  logic retire_valid_i = 1'b0, suspend_valid_i = 1'b0, resume_valid_i = 1'b0;
  logic [TID_W-1:0] retire_tid_i = '0, suspend_tid_i = '0, resume_tid_i = '0;
  logic issue_valid_o;
  logic [TID_W-1:0] issue_tid_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  int m_st [N];
  int m_ptr;
  int unsigned seed_dummy;

  always #2 clk = ~clk;

  barrel_sched #(.NUM_THREADS(N)) i_barrel_sched (
    .clk_i(clk), .rst_ni(rst_ni), .issue_ready_i(issue_ready_i),
    .retire_valid_i(retire_valid_i), .retire_tid_i(retire_tid_i),
    .suspend_valid_i(suspend_valid_i), .suspend_tid_i(suspend_tid_i),
    .resume_valid_i(resume_valid_i), .resume_tid_i(resume_tid_i),
    .issue_valid_o(issue_valid_o), .issue_tid_o(issue_tid_o));

  function automatic int exp_pick();
    for (int i = 0; i < N; i++) begin
      int t = (m_ptr + i) % N;
      if (m_st[t] == S_RDY) return t;
    end
    return -1;
  endfunction

  function automatic int find_in(int s, int start);
    for (int i = 0; i < N; i++) begin
      int t = (start + i) % N;
      if (m_st[t] == s) return t;
    end
    return start % N;
  endfunction

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, compare, advance model across posedge
  task automatic step(string req, bit ir, bit rv, int rt, bit sv, int stid,
                      bit mv, int mt);
    int p;
    bit fire;
    @(negedge clk);
    issue_ready_i = ir;
    retire_valid_i = rv;  retire_tid_i = TID_W'(rt);
    suspend_valid_i = sv; suspend_tid_i = TID_W'(stid);
    resume_valid_i = mv;  resume_tid_i = TID_W'(mt);
    #1;
    p = exp_pick();
    check(req, int'(issue_valid_o), int'(p >= 0), "issue_valid");
    if (p >= 0) check(req, int'(issue_tid_o), p, "issue_tid");
    fire = ir && (p >= 0);
    for (int t = 0; t < N; t++) begin
      case (m_st[t])
        S_RDY: if (fire && p == t) m_st[t] = S_BSY;
        S_BSY: begin
          if (sv && stid == t)      m_st[t] = S_PRK;
          else if (rv && rt == t)   m_st[t] = S_RDY;
        end
        default: if (mv && mt == t) m_st[t] = S_RDY;
      endcase
    end
    if (fire) m_ptr = (p + 1) % N;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    seed_dummy = $urandom(32'd1234);
    for (int t = 0; t < N; t++) m_st[t] = S_RDY;
    m_ptr = 0;
    #5;
    // R1: reset state seen before the first edge after release
    check("R1", int'(issue_valid_o), 1, "issue_valid");
    check("R1", int'(issue_tid_o), 0, "issue_tid");
    @(negedge clk); rst_ni = 1'b1;

    // R2: plain rotation from thread 0
    for (int i = 0; i < N; i++) step("R2", 1, 0, 0, 0, 0, 0, 0);
    // R4: everything busy, bubble
    step("R4", 1, 0, 0, 0, 0, 0, 0);
    // R6: suspend and retire of thread 3 together
    step("R6", 1, 1, 3, 1, 3, 0, 0);
    // R5: retire thread 7, then it issues; R7: thread 3 stays out
    step("R5", 1, 1, 7, 0, 0, 0, 0);
    step("R5", 1, 0, 0, 0, 0, 0, 0);
    step("R7", 1, 0, 0, 0, 0, 0, 0);
    // R8: resume for busy thread 9 is ignored
    step("R8", 1, 0, 0, 0, 0, 1, 9);
    step("R8", 1, 0, 0, 0, 0, 0, 0);
    // R9: resume 3 and retire 10 in one cycle
    step("R9", 0, 1, 10, 0, 0, 1, 3);
    // R10: front end not ready, offer must hold
    step("R10", 0, 0, 0, 0, 0, 0, 0);
    step("R10", 0, 0, 0, 0, 0, 0, 0);
    // R11: retire and suspend of ready threads 3 and 10 ignored
    step("R11", 0, 1, 3, 1, 10, 0, 0);
    step("R11", 1, 0, 0, 0, 0, 0, 0);
    step("R11", 1, 0, 0, 0, 0, 0, 0);
    step("R4", 1, 0, 0, 0, 0, 0, 0);
    // R8: resume for ready thread after retire
    step("R8", 1, 1, 0, 0, 0, 0, 0);
    step("R8", 0, 0, 0, 0, 0, 1, 0);
    step("R8", 1, 0, 0, 0, 0, 0, 0);

    // R3: constrained random traffic
    for (int c = 0; c < 4000; c++) begin
      bit ir, rv, sv, mv;
      int rt, stid, mt;
      ir = ($urandom_range(0, 9) < 8);
      rv = ($urandom_range(0, 9) < 6);
      rt = ($urandom_range(0, 1) != 0) ? find_in(S_BSY, $urandom_range(0, N-1))
                                        : $urandom_range(0, N-1);
      sv = ($urandom_range(0, 9) < 2);
      stid = ($urandom_range(0, 9) < 3) ? rt
             : find_in(S_BSY, $urandom_range(0, N-1));
      mv = ($urandom_range(0, 9) < 4);
      mt = ($urandom_range(0, 9) < 7) ? find_in(S_PRK, $urandom_range(0, N-1))
                                      : $urandom_range(0, N-1);
      step("R3", ir, rv, rt, sv, stid, mv, mt);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule